// File: doc/BRIEF.md
# Byte Memory DMA Engine

This block moves a run of words between an 8-bit wide external byte memory and the chip's internal program or data memory. Software programs the job through a small register port: an external page and offset, an internal start address, a control word and a word count. Writing a nonzero count starts the job. In load direction the engine reads bytes and assembles each internal word from them. In store direction it reads each internal word once and sends it out as bytes. Every byte access is stretched by a programmable number of wait states. Each finished word takes exactly one internal memory cycle.

The core's own external accesses always win. The engine only starts a byte access in a cycle where the core is not asking for the external bus. The job can either run beside the core or hold the core for its whole length. When the core was held, it is released at the end with a one-cycle restart pulse that tells it to begin again at address 0. The words still to be moved can be read at any time, and a one-cycle interrupt marks the end of the job.

Top module: `bmdma_engine`

## Requirements
- R1: Register select codes on `cfg_sel` are: 0 = page (data bits 7:0), 1 = external offset (bits 13:0), 2 = internal start address (bits 13:0), 3 = control, 4 = word count (bits 13:0). The control word holds format in bits 1:0, direction in bit 2 (0 = byte memory to internal, 1 = internal to byte memory), hold in bit 3 and wait states in bits 7:4.
- R2: A write of a nonzero count while idle starts a job, and `busy` rises in the next cycle. A write of zero starts nothing.
- R3: In load direction the bytes of a word arrive most significant first. Format 00 builds a 24-bit program word from three bytes {b0,b1,b2}. Format 01 builds a 16-bit data word {b0,b1}. Format 10 places one byte in data bits 15:8. Format 11 places one byte in data bits 7:0. `im_pm` is 1 only for format 00.
- R4: Bits of `im_wdata` that a format does not fill are 0. For the data formats this includes bits 23:16.
- R5: In store direction each internal word is sent most significant byte first. Format 00 sends bits 23:16, 15:8 and 7:0. Format 01 sends bits 15:8 and 7:0. Format 10 sends only bits 15:8. Format 11 sends only bits 7:0.
- R6: The byte address is the 22-bit value {page, offset}. It goes up by one after every byte, and a carry out of the offset increments the page.
- R7: Each byte access holds `bm_req` high for exactly wait+1 cycles. `bm_req` is low for at least one cycle between accesses.
- R8: A byte access never begins in the cycle after `core_ext_req` was sampled high. The engine waits until the core lets go.
- R9: Each word uses exactly one `im_req` cycle. The internal address starts at the programmed value and increments by one per word.
- R10: `words_left` shows the programmed count and decrements once per finished word. When it reaches zero, `busy` falls and `irq` pulses high for one cycle.
- R11: With hold set, `core_hold` is high for exactly as long as `busy`, and `core_restart` pulses once as the job ends. With hold clear, neither output is asserted.
- R12: Register writes made while `busy` is high have no effect on the running job or on its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 14 | Register write data |
| words_left | output | 14 | Remaining word count |
| busy | output | 1 | Job in progress |
| irq | output | 1 | One-cycle completion pulse |
| core_ext_req | input | 1 | Core wants the external bus this cycle |
| core_hold | output | 1 | Core stalled by the engine |
| core_restart | output | 1 | Core restarts at address 0 |
| bm_req | output | 1 | Byte access active |
| bm_we | output | 1 | Byte access is a write |
| bm_addr | output | 22 | Byte address |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data, sampled in the last access cycle |
| im_req | output | 1 | Internal memory cycle |
| im_we | output | 1 | Internal write |
| im_pm | output | 1 | 1 = program memory, 0 = data memory |
| im_addr | output | 14 | Internal word address |
| im_wdata | output | 24 | Internal write word |
| im_rdata | input | 24 | Internal read word, valid the cycle after the read |

## Verification
Directed jobs cover each of the four formats in both directions. They tell apart byte order, byte placement and zero fill, since each format puts the same byte stream into a different part of the word. One job starts at offset 0x3FFE so that its bytes cross into the next page. Another uses 15 wait states, and a third writes new register values in the middle of a job. Seeded random jobs then mix formats, directions, wait counts, hold and lengths while the core bus request toggles. These show that stalls stretch the job without reordering or dropping bytes.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 24;

  localparam logic [2:0] SEL_PAGE  = 3'd0;
  localparam logic [2:0] SEL_OFFS  = 3'd1;
  localparam logic [2:0] SEL_IADDR = 3'd2;
  localparam logic [2:0] SEL_CTRL  = 3'd3;
  localparam logic [2:0] SEL_COUNT = 3'd4;

  typedef enum logic [1:0] {
    FMT_PM24   = 2'b00,
    FMT_DM16   = 2'b01,
    FMT_DM8_HI = 2'b10,
    FMT_DM8_LO = 2'b11
  } fmt_e;

  function automatic logic [1:0] bytes_per_word(fmt_e f);
    case (f)
      FMT_PM24: return 2'd3;
      FMT_DM16: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction

  // acc holds the received bytes right-justified, last byte in bits 7:0
  function automatic logic [WORD_W-1:0] place_load(fmt_e f, logic [WORD_W-1:0] acc);
    case (f)
      FMT_PM24:   return acc;
      FMT_DM16:   return {8'h00, acc[15:0]};
      FMT_DM8_HI: return {8'h00, acc[7:0], 8'h00};
      default:    return {16'h0000, acc[7:0]};
    endcase
  endfunction

  // returns the word with its first outgoing byte in bits 23:16
  function automatic logic [WORD_W-1:0] align_store(fmt_e f, logic [WORD_W-1:0] w);
    case (f)
      FMT_PM24:   return w;
      FMT_DM16:   return {w[15:0], 8'h00};
      FMT_DM8_HI: return {w[15:8], 16'h0000};
      default:    return {w[7:0], 16'h0000};
    endcase
  endfunction
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 14,
  parameter int IADDR_W = 14,
  parameter int CNT_W   = 14,
  parameter int WAIT_W  = 4,
  localparam int EXT_W  = PAGE_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [OFF_W-1:0]   cfg_wdata,
  input  logic               busy,
  input  logic               byte_step,
  input  logic               word_step,
  output fmt_e               fmt,
  output logic               dir,
  output logic               hold,
  output logic [WAIT_W-1:0]  wait_n,
  output logic [EXT_W-1:0]   ext_addr,
  output logic [IADDR_W-1:0] int_addr,
  output logic [CNT_W-1:0]   count,
  output logic               start
);
  logic wr_ok;
  assign wr_ok = cfg_we && !busy;
  assign start = wr_ok && (cfg_sel == SEL_COUNT) && (cfg_wdata[CNT_W-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt <= FMT_PM24; dir <= 1'b0; hold <= 1'b0; wait_n <= '0;
      ext_addr <= '0; int_addr <= '0; count <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        SEL_PAGE:  ext_addr[EXT_W-1:OFF_W] <= cfg_wdata[PAGE_W-1:0];
        SEL_OFFS:  ext_addr[OFF_W-1:0] <= cfg_wdata;
        SEL_IADDR: int_addr <= cfg_wdata[IADDR_W-1:0];
        SEL_CTRL: begin
          fmt    <= fmt_e'(cfg_wdata[1:0]);
          dir    <= cfg_wdata[2];
          hold   <= cfg_wdata[3];
          wait_n <= cfg_wdata[4 +: WAIT_W];
        end
        SEL_COUNT: count <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end else begin
      if (byte_step) ext_addr <= ext_addr + EXT_W'(1);
      if (word_step) begin
        int_addr <= int_addr + IADDR_W'(1);
        count    <= count - CNT_W'(1);
      end
    end
  end

  // R6: offset carry moves into the page
  a_r6_page_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_step && !wr_ok && (ext_addr[OFF_W-1:0] == '1)) |=>
      (ext_addr[EXT_W-1:OFF_W] == PAGE_W'($past(ext_addr[EXT_W-1:OFF_W]) + PAGE_W'(1))));
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
  import bmdma_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  fmt_e              fmt,
  input  logic              dir,
  input  logic              hold,
  input  logic [WAIT_W-1:0] wait_n,
  input  logic              core_ext_req,
  input  logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              bm_req,
  output logic              bm_we,
  output logic              im_req,
  output logic              im_we,
  output logic              grab,
  output logic              byte_step,
  output logic              word_step,
  output logic              irq,
  output logic              core_restart
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_GRAB, S_ARB, S_ACC, S_PUT} state_e;
  state_e state;
  logic [WAIT_W-1:0] wcnt;
  logic [1:0] bidx;
  logic last_byte, last_word;

  assign last_byte = (bidx == 2'(bytes_per_word(fmt) - 2'd1));
  assign last_word = (count == CNT_W'(1));
  assign busy      = (state != S_IDLE);
  assign bm_req    = (state == S_ACC);
  assign bm_we     = bm_req && dir;
  assign im_req    = (state == S_FETCH) || (state == S_PUT);
  assign im_we     = (state == S_PUT);
  assign grab      = (state == S_GRAB);
  assign byte_step = bm_req && (wcnt == '0);
  assign word_step = (state == S_PUT) || (byte_step && last_byte && dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; wcnt <= '0; bidx <= '0;
      irq <= 1'b0; core_restart <= 1'b0;
    end else begin
      irq <= 1'b0;
      core_restart <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= dir ? S_FETCH : S_ARB;
          bidx  <= '0;
        end
        S_FETCH: state <= S_GRAB;
        S_GRAB:  state <= S_ARB;
        S_ARB: if (!core_ext_req) begin
          state <= S_ACC;
          wcnt  <= wait_n;
        end
        S_ACC: begin
          if (wcnt != '0) wcnt <= wcnt - WAIT_W'(1);
          else if (!last_byte) begin
            bidx  <= bidx + 2'd1;
            state <= S_ARB;
          end else begin
            bidx <= '0;
            if (!dir) state <= S_PUT;
            else if (last_word) begin
              state <= S_IDLE; irq <= 1'b1; core_restart <= hold;
            end else state <= S_FETCH;
          end
        end
        S_PUT: begin
          if (last_word) begin
            state <= S_IDLE; irq <= 1'b1; core_restart <= hold;
          end else state <= S_ARB;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: core request seen at an edge blocks a byte access starting after it
  a_r8_core_first: assert property (@(posedge clk) disable iff (!rst_n)
    core_ext_req |=> !$rose(bm_req));
  // R2: accepted start makes the engine busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/bmdma_pack.sv
module bmdma_pack
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              dir,
  input  logic              grab,
  input  logic              byte_step,
  input  logic [WORD_W-1:0] im_rdata,
  input  logic [BYTE_W-1:0] bm_rdata,
  output logic [BYTE_W-1:0] bm_wdata,
  output logic [WORD_W-1:0] im_wdata
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else if (grab) sh <= align_store(fmt, im_rdata);
    else if (byte_step) sh <= {sh[WORD_W-BYTE_W-1:0], dir ? 8'h00 : bm_rdata};
  end

  assign bm_wdata = sh[WORD_W-1:WORD_W-BYTE_W];
  assign im_wdata = place_load(fmt, sh);
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 14,
  parameter int IADDR_W = 14,
  parameter int CNT_W   = 14,
  parameter int WAIT_W  = 4,
  localparam int EXT_W  = PAGE_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [OFF_W-1:0]   cfg_wdata,
  output logic [CNT_W-1:0]   words_left,
  output logic               busy,
  output logic               irq,
  input  logic               core_ext_req,
  output logic               core_hold,
  output logic               core_restart,
  output logic               bm_req,
  output logic               bm_we,
  output logic [EXT_W-1:0]   bm_addr,
  output logic [BYTE_W-1:0]  bm_wdata,
  input  logic [BYTE_W-1:0]  bm_rdata,
  output logic               im_req,
  output logic               im_we,
  output logic               im_pm,
  output logic [IADDR_W-1:0] im_addr,
  output logic [WORD_W-1:0]  im_wdata,
  input  logic [WORD_W-1:0]  im_rdata
);
  fmt_e fmt;
  logic dir, hold, start, grab, byte_step, word_step;
  logic [WAIT_W-1:0] wait_n;

  bmdma_regs #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .IADDR_W(IADDR_W), .CNT_W(CNT_W),
               .WAIT_W(WAIT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .byte_step(byte_step), .word_step(word_step), .fmt(fmt), .dir(dir),
    .hold(hold), .wait_n(wait_n), .ext_addr(bm_addr), .int_addr(im_addr),
    .count(words_left), .start(start));

  bmdma_seq #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .dir(dir), .hold(hold),
    .wait_n(wait_n), .core_ext_req(core_ext_req), .count(words_left), .busy(busy),
    .bm_req(bm_req), .bm_we(bm_we), .im_req(im_req), .im_we(im_we), .grab(grab),
    .byte_step(byte_step), .word_step(word_step), .irq(irq), .core_restart(core_restart));

  bmdma_pack u_pack (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .dir(dir), .grab(grab), .byte_step(byte_step),
    .im_rdata(im_rdata), .bm_rdata(bm_rdata), .bm_wdata(bm_wdata), .im_wdata(im_wdata));

  assign core_hold = busy && hold;
  assign im_pm     = (fmt == FMT_PM24);

  // length of the current byte access, for the wait-state check
  logic [WAIT_W:0] acc_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_len <= '0;
    else if (bm_req) acc_len <= acc_len + (WAIT_W+1)'(1);
    else acc_len <= '0;
  end

  // R7: every access lasts wait+1 cycles
  a_r7_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bm_req) |-> (acc_len == ({1'b0, wait_n} + (WAIT_W+1)'(1))));
  // R10: completion pulse only with an empty count and an idle engine
  a_r10_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (words_left == '0 && !busy));
  // R11: releasing the core comes with the restart pulse
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> core_restart);
  // R4: data-memory words keep the top byte clear
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (im_req && im_we && !im_pm) |-> (im_wdata[WORD_W-1:16] == 8'h00));
endmodule

// File: tb/bmdma_engine_test.sv
module bmdma_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [13:0] cfg_wdata = '0;
  logic [13:0] words_left;
  logic busy, irq, core_hold, core_restart;
  logic core_ext_req = 1'b0;
  logic bm_req, bm_we, im_req, im_we, im_pm;
  logic [21:0] bm_addr;
  logic [7:0] bm_wdata, bm_rdata;
  logic [13:0] im_addr;
  logic [23:0] im_wdata;
  logic [23:0] im_rdata = '0;

  always #5 clk = ~clk;

  bmdma_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .words_left(words_left), .busy(busy), .irq(irq), .core_ext_req(core_ext_req),
    .core_hold(core_hold), .core_restart(core_restart), .bm_req(bm_req), .bm_we(bm_we),
    .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .im_req(im_req),
    .im_we(im_we), .im_pm(im_pm), .im_addr(im_addr), .im_wdata(im_wdata),
    .im_rdata(im_rdata));

  int checks = 0;
  int fails = 0;

  function automatic logic [7:0] bpat(logic [21:0] a);
    return 8'((a[7:0] * 8'd29) ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'hA5);
  endfunction
  function automatic logic [23:0] ipat(logic [13:0] a, logic pm);
    logic [23:0] v = 24'(a * 24'h01F3A1) ^ 24'h5C3A96;
    return pm ? v : {8'h00, v[15:0]};
  endfunction
  function automatic int nbytes(int f);
    return (f == 0) ? 3 : (f == 1) ? 2 : 1;
  endfunction
  function automatic logic [23:0] exp_load(int f, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    if (f == 0) return {b0, b1, b2};
    if (f == 1) return {8'h00, b0, b1};
    if (f == 2) return {8'h00, b0, 8'h00};
    return {16'h0000, b0};
  endfunction
  function automatic logic [7:0] exp_store(int f, logic [23:0] w, int j);
    if (f == 0) return (j == 0) ? w[23:16] : (j == 1) ? w[15:8] : w[7:0];
    if (f == 1) return (j == 0) ? w[15:8] : w[7:0];
    if (f == 2) return w[15:8];
    return w[7:0];
  endfunction

  assign bm_rdata = bpat(bm_addr);

  logic [23:0] pm_mem [256];
  logic [23:0] dm_mem [256];
  logic [7:0] bstore [int unsigned];

  always @(posedge clk) begin
    if (im_req && !im_we) im_rdata <= im_pm ? pm_mem[im_addr[7:0]] : dm_mem[im_addr[7:0]];
    if (im_req && im_we) begin
      if (im_pm) pm_mem[im_addr[7:0]] <= im_wdata;
      else dm_mem[im_addr[7:0]] <= im_wdata;
    end
  end

  int core_pct = 0;
  initial forever begin
    @(posedge clk); #2;
    core_ext_req = (($urandom % 100) < core_pct);
  end

  // monitor state
  int exp_wait = 0;
  logic exp_hold = 1'b0;
  logic [21:0] exp_addr = '0;
  logic [13:0] exp_iaddr = '0;
  int wait_err = 0, prio_err = 0, addr_err = 0, iaddr_err = 0, hold_err = 0;
  int im_cnt = 0, rst_cnt = 0, len = 0;
  logic pr_bm = 1'b0, pr_core = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bm_req) len++;
      else if (pr_bm) begin
        if (len != exp_wait + 1) wait_err++;
        len = 0;
      end
      if (bm_req && !pr_bm) begin
        if (pr_core) prio_err++;
        if (bm_addr != exp_addr) addr_err++;
        exp_addr = exp_addr + 22'd1;
      end
      if (bm_req && bm_we) bstore[32'(bm_addr)] = bm_wdata;
      if (im_req) begin
        im_cnt++;
        if (im_addr != exp_iaddr) iaddr_err++;
        exp_iaddr = exp_iaddr + 14'd1;
      end
      if (core_restart) rst_cnt++;
      if (core_hold !== (exp_hold && busy)) hold_err++;
      pr_bm = bm_req;
      pr_core = core_ext_req;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [13:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(output int ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  // one full job with all port-level checks
  task automatic job(int f, int d, int h, int w, logic [7:0] pg, logic [13:0] off,
                     logic [13:0] ia, int n, int poke);
    int ok;
    logic [21:0] base;
    base = {pg, off};
    for (int k = 0; k < n; k++) begin
      pm_mem[8'(ia + 14'(k))] = ipat(ia + 14'(k), 1'b1);
      dm_mem[8'(ia + 14'(k))] = ipat(ia + 14'(k), 1'b0);
    end
    bstore.delete();
    wr(3'd0, {6'd0, pg});
    wr(3'd1, off);
    wr(3'd2, ia);
    wr(3'd3, 14'({4'(w), 1'(h), 1'(d), 2'(f)}));
    exp_wait = w; exp_hold = 1'(h); exp_addr = base; exp_iaddr = ia;
    wait_err = 0; prio_err = 0; addr_err = 0; iaddr_err = 0; hold_err = 0;
    im_cnt = 0; rst_cnt = 0;
    wr(3'd4, 14'(n));
    check("R2", "busy after start", int'(busy), 1);
    check("R10", "count readable", int'(words_left), n);
    if (poke != 0) begin
      // R12: writes during a job must not disturb it
      wr(3'd4, 14'd7);
      wr(3'd0, 14'h055);
      wr(3'd3, 14'h0F3);
      check("R12", "count untouched", int'(words_left) <= n ? 1 : 0, 1);
    end
    wait_done(ok);
    check("R10", "completion seen", ok, 1);
    check("R10", "count zero at irq", int'(words_left), 0);
    check("R10", "idle at irq", int'(busy), 0);
    @(posedge clk); #1;
    check("R10", "irq single cycle", int'(irq), 0);
    check("R7", "wait-stated access lengths", wait_err, 0);
    check("R8", "core priority", prio_err, 0);
    check("R6", "byte address sequence", addr_err, 0);
    check("R9", "internal cycles per job", im_cnt, n);
    check("R9", "internal address sequence", iaddr_err, 0);
    check("R11", "hold tracks busy", hold_err, 0);
    check("R11", "restart pulses", rst_cnt, h);
    for (int k = 0; k < n; k++) begin
      logic [13:0] a = ia + 14'(k);
      if (d == 0) begin
        logic [21:0] e = base + 22'(k * nbytes(f));
        logic [23:0] got = (f == 0) ? pm_mem[a[7:0]] : dm_mem[a[7:0]];
        logic [23:0] exp = exp_load(f, bpat(e), bpat(e + 22'd1), bpat(e + 22'd2));
        check((f >= 2) ? "R4" : "R3", "loaded word", int'(got), int'(exp));
      end else begin
        logic [23:0] src = ipat(a, f == 0);
        for (int j = 0; j < nbytes(f); j++) begin
          logic [21:0] e = base + 22'(k * nbytes(f) + j);
          int got = bstore.exists(32'(e)) ? int'(bstore[32'(e)]) : -1;
          check("R5", "stored byte", got, int'(exp_store(f, src, j)));
        end
      end
    end
    exp_hold = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h2187));
    for (int i = 0; i < 256; i++) begin pm_mem[i] = '0; dm_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // reset state
    check("R10", "reset count", int'(words_left), 0);
    check("R2", "reset busy", int'(busy), 0);
    check("R10", "reset irq", int'(irq), 0);
    check("R11", "reset hold", int'(core_hold), 0);
    check("R7", "reset bm_req", int'(bm_req), 0);
    check("R9", "reset im_req", int'(im_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // zero count must not start
    wr(3'd4, 14'd0);
    repeat (3) @(negedge clk);
    check("R2", "zero count stays idle", int'(busy), 0);
    check("R2", "zero count no byte access", int'(bm_req), 0);
    // R1 R3 R6: program words across a page boundary
    job(0, 0, 0, 3, 8'h02, 14'h3FFE, 14'd10, 2, 0);
    check("R1", "program space selected by format 00", int'(im_pm), 1);
    // R3 R4: 16-bit data load with maximum waits
    job(1, 0, 0, 15, 8'h11, 14'h0100, 14'd40, 3, 0);
    // R4: byte in upper and lower half
    job(2, 0, 0, 0, 8'h00, 14'h0020, 14'd60, 3, 0);
    job(3, 0, 0, 1, 8'h00, 14'h0030, 14'd70, 3, 0);
    // R5: stores in every format
    job(0, 1, 0, 2, 8'h05, 14'h3FFF, 14'd80, 2, 0);
    job(1, 1, 0, 0, 8'h06, 14'h0200, 14'd90, 2, 0);
    job(2, 1, 0, 1, 8'h07, 14'h0300, 14'd100, 2, 0);
    job(3, 1, 0, 0, 8'h08, 14'h0400, 14'd110, 2, 0);
    // R11: core held then restarted
    job(1, 0, 1, 2, 8'h09, 14'h0500, 14'd120, 2, 0);
    // R12: register writes during a job
    job(0, 0, 0, 4, 8'h0A, 14'h0600, 14'd130, 3, 1);
    // random mix with core bus traffic
    core_pct = 30;
    for (int r = 0; r < 12; r++) begin
      job(int'($urandom % 4), int'($urandom % 2), int'($urandom % 2), int'($urandom % 16),
          8'($urandom), 14'($urandom), 14'(140 + ($urandom % 100)), 1 + int'($urandom % 6), 0);
    end
    core_pct = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule